// File: doc/BRIEF.md
# Programmed-I/O Cycle Timing Sequencer

This block runs one programmed-I/O read or write cycle on a parallel ATA-style device bus for each request it takes. A host presents a 4-bit register address, a write flag and 16-bit write data on a valid/ready request channel. The block places the address on the device bus and waits through a setup phase. It then pulses the read or write strobe and finishes with a recovery phase. When the cycle ends it returns a one-cycle response pulse with the 16-bit read data. The device's IORDY line can stretch the strobe.

Every phase length is a programmed 8-bit count n, and a phase with count n lasts n+1 clock cycles. There are three timing sets, each with its own IORDY enable. One set serves command-register accesses. The other two are fast data-port sets, one for device 0 and one for device 1. Data-port timing applies only to register address 0, and only when the fast-timing enable bit of the current device is set. Otherwise the command set applies. The current device is a shadow of bit 4 of the last write to register address 6.

Back-pressure rules: `req_ready` is high only while no cycle is running, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The response channel has no ready signal. The host must take `rsp_valid` in the single cycle it is high. `dev_iordy` must already be synchronous to `clk`. The set, its IORDY enable and the request fields are latched when the request is accepted.

Top module: `pio_cycle_seq`

## Requirements
- R1: `req_ready` is high and `busy` low exactly when no cycle is running. A request accepted on edge E makes `busy` high and `req_ready` low from E until the response edge, and `busy` is low in the response cycle.
- R2: The address on `dev_addr` is valid for T1+1 cycles before the strobe rises, counting from the cycle after acceptance. T1 is bits 7:0 of the selected timing word.
- R3: With IORDY not stretching, the strobe is high for exactly T2+1 cycles. T2 is bits 15:8 of the timing word.
- R4: After the strobe falls, the recovery phase lasts Teoc+1 cycles (bits 31:24). The following cycle carries `rsp_valid` high for exactly one cycle.
- R5: For a read, `rsp_rdata` equals the value of `dev_rdata` sampled at the clock edge where the read strobe falls. Later changes on `dev_rdata` do not affect it.
- R6: For a write, `dev_wdata_oe` is high with `dev_wdata` equal to the request data from the first setup cycle through min(T4,Teoc)+1 cycles after the strobe falls. T4 is bits 23:16. `dev_wdata_oe` never rises on a read.
- R7: The timing set is chosen as follows. Device 0's set (`cfg_dev0_timing`) applies when the address is 0 and `cfg_fast_en[0]` is set with device 0 current. Device 1's set (`cfg_dev1_timing`) applies when the address is 0 and `cfg_fast_en[1]` is set with device 1 current. Every other access uses `cfg_cmd_timing`.
- R8: The current device is 0 after reset. Accepting a write to address 6 sets it to bit 4 of the write data, and that value takes effect from the next access. Reads of address 6 do not change it.
- R9: When the IORDY enable of the selected set is 1, the strobe continues past T2+1 cycles for as long as `dev_iordy` is low at the end of its last cycle. When that enable is 0, `dev_iordy` has no effect on cycle length. The enable bits are `cfg_iordy_en` bit 0 for command, bit 1 for device 0 and bit 2 for device 1.
- R10: Changes to the `cfg_*` inputs after acceptance do not alter the running cycle. `dev_addr` stays stable for the whole cycle.
- R11: While `rst_n` is low, and right after it, the block is idle, with ready high, both strobes low, the data drive off and no response.
- R12: Only the strobe matching the access direction ever rises: `dev_rd_stb` for reads, `dev_wr_stb` for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 4 | Device register address |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle end-of-cycle acknowledge |
| rsp_rdata | output | 16 | Captured read data |
| busy | output | 1 | Cycle in progress |
| cfg_cmd_timing | input | 32 | Command set {Teoc,T4,T2,T1} |
| cfg_dev0_timing | input | 32 | Device 0 data-port set {Teoc,T4,T2,T1} |
| cfg_dev1_timing | input | 32 | Device 1 data-port set {Teoc,T4,T2,T1} |
| cfg_iordy_en | input | 3 | IORDY enable per set (cmd, dev0, dev1) |
| cfg_fast_en | input | 2 | Fast data-port timing enable per device |
| dev_addr | output | 4 | Device bus address |
| dev_rd_stb | output | 1 | Read strobe, active high |
| dev_wr_stb | output | 1 | Write strobe, active high |
| dev_wdata | output | 16 | Device bus write data |
| dev_wdata_oe | output | 1 | Write data drive enable |
| dev_rdata | input | 16 | Device bus read data |
| dev_iordy | input | 1 | Device wait input, low = not ready |

## Verification
The response of one cycle and the acceptance of the next can fall in the same cycle, because `req_ready` returns high in the response cycle. The bench provokes this by presenting each new request in the response cycle of the previous one. A write to address 6 is followed at once by an address-0 access. Correct behaviour requires the shadowed device bit to be updated by the finished write in time for the next access. The bench judges this by measuring the setup, strobe and recovery lengths of that next access against the set it expects from its own device model.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int CNT_W  = 8;
  localparam int TIM_W  = 4 * CNT_W;
  localparam int N_DEV  = 2;
  localparam int N_SETS = N_DEV + 1;
  localparam int SET_W  = $clog2(N_SETS);

  typedef struct packed {
    logic [CNT_W-1:0] t_eoc;
    logic [CNT_W-1:0] t_hold;
    logic [CNT_W-1:0] t_strobe;
    logic [CNT_W-1:0] t_setup;
  } pio_timing_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;

  localparam pio_timing_t MODE0_TIMING = '{
    t_eoc:    CNT_W'(23),
    t_hold:   CNT_W'(2),
    t_strobe: CNT_W'(28),
    t_setup:  CNT_W'(6)
  };
endpackage

// File: rtl/pio_dev_shadow.sv
module pio_dev_shadow #(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int DEV_REG     = 6,
  parameter int DEV_BIT_POS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  output logic          dev_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_sel <= 1'b0;
    end else if (accept && write && addr == AW'(DEV_REG)) begin
      dev_sel <= wdata[DEV_BIT_POS];
    end
  end

  // R8: device bit only moves on an accepted request
  p_dev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(dev_sel));
endmodule

// File: rtl/pio_set_select.sv
module pio_set_select
  import pio_seq_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DATA_PORT = 0
) (
  input  logic [AW-1:0]                addr,
  input  logic                         dev_sel,
  input  logic [N_SETS-1:0][TIM_W-1:0] set_cfg,
  input  logic [N_SETS-1:0]            iordy_en,
  input  logic [N_DEV-1:0]             fast_en,
  output pio_timing_t                  timing,
  output logic                         iordy_use
);
  logic [SET_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int d = 0; d < N_DEV; d++) begin
      if (addr == AW'(DATA_PORT) && fast_en[d] && dev_sel == d[0]) begin
        idx = SET_W'(d + 1);
      end
    end
  end

  always_comb begin
    timing    = set_cfg[0];
    iordy_use = iordy_en[0];
    for (int s = 1; s < N_SETS; s++) begin
      if (idx == SET_W'(s)) begin
        timing    = set_cfg[s];
        iordy_use = iordy_en[s];
      end
    end
  end
endmodule

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
  import pio_seq_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_write,
  input  logic [DW-1:0] start_wdata,
  input  pio_timing_t   start_timing,
  input  logic          start_iordy_en,
  input  logic          dev_iordy,
  input  logic [DW-1:0] dev_rdata,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] dev_addr,
  output logic          dev_rd_stb,
  output logic          dev_wr_stb,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_wdata_oe
);
  pio_phase_e       phase;
  pio_timing_t      tim_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_cnt;
  logic             hold_on;
  logic             iordy_en_q;
  logic             write_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rdata_q;
  logic             done_q;
  logic             last_tick;
  logic             dev_wait;

  assign last_tick = (cnt == '0);
  assign dev_wait  = iordy_en_q && !dev_iordy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      tim_q      <= '0;
      cnt        <= '0;
      hold_cnt   <= '0;
      hold_on    <= 1'b0;
      iordy_en_q <= 1'b0;
      write_q    <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase      <= PH_SETUP;
            tim_q      <= start_timing;
            cnt        <= start_timing.t_setup;
            iordy_en_q <= start_iordy_en;
            write_q    <= start_write;
            addr_q     <= start_addr;
            wdata_q    <= start_wdata;
          end
        end
        PH_SETUP: begin
          if (last_tick) begin
            phase <= PH_STROBE;
            cnt   <= tim_q.t_strobe;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (last_tick) begin
            if (!dev_wait) begin
              phase    <= PH_RECOV;
              cnt      <= tim_q.t_eoc;
              hold_cnt <= tim_q.t_hold;
              hold_on  <= write_q;
              if (!write_q) begin
                rdata_q <= dev_rdata;
              end
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_RECOV: begin
          if (hold_cnt == '0) begin
            hold_on <= 1'b0;
          end else begin
            hold_cnt <= hold_cnt - CNT_W'(1);
          end
          if (last_tick) begin
            phase   <= PH_IDLE;
            done_q  <= 1'b1;
            hold_on <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle         = (phase == PH_IDLE);
  assign done         = done_q;
  assign rdata        = rdata_q;
  assign dev_addr     = addr_q;
  assign dev_rd_stb   = (phase == PH_STROBE) && !write_q;
  assign dev_wr_stb   = (phase == PH_STROBE) && write_q;
  assign dev_wdata_oe = write_q && ((phase == PH_SETUP) || (phase == PH_STROBE) ||
                                    (phase == PH_RECOV && hold_on));
  assign dev_wdata    = dev_wdata_oe ? wdata_q : '0;

  // R4: acknowledge lasts one cycle and follows the recovery phase
  p_single_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ack_after_recov_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase == PH_RECOV));
  // R9: a not-ready device at the last strobe cycle keeps the strobe up
  p_iordy_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && last_tick && iordy_en_q && !dev_iordy)
      |=> (dev_rd_stb || dev_wr_stb));
  // R10: address is held through the whole cycle
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle)) |-> $stable(dev_addr));
  // R12: never both strobes
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd_stb && dev_wr_stb));
  // R6: data drive only on writes, and it starts only from idle
  p_oe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_wdata_oe) |-> $past(idle) && write_q);
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int DATA_PORT   = 0,
  parameter int DEV_REG     = 6,
  parameter int DEV_BIT_POS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             busy,
  input  logic [TIM_W-1:0] cfg_cmd_timing,
  input  logic [TIM_W-1:0] cfg_dev0_timing,
  input  logic [TIM_W-1:0] cfg_dev1_timing,
  input  logic [N_SETS-1:0] cfg_iordy_en,
  input  logic [N_DEV-1:0] cfg_fast_en,
  output logic [AW-1:0]    dev_addr,
  output logic             dev_rd_stb,
  output logic             dev_wr_stb,
  output logic [DW-1:0]    dev_wdata,
  output logic             dev_wdata_oe,
  input  logic [DW-1:0]    dev_rdata,
  input  logic             dev_iordy
);
  logic                         idle;
  logic                         accept;
  logic                         dev_sel;
  logic [N_SETS-1:0][TIM_W-1:0] set_cfg;
  pio_timing_t                  sel_timing;
  logic                         sel_iordy;

  assign set_cfg   = {cfg_dev1_timing, cfg_dev0_timing, cfg_cmd_timing};
  assign req_ready = idle;
  assign busy      = !idle;
  assign accept    = req_valid && req_ready;

  pio_dev_shadow #(
    .AW(AW), .DW(DW), .DEV_REG(DEV_REG), .DEV_BIT_POS(DEV_BIT_POS)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr(req_addr),
    .write(req_write), .wdata(req_wdata), .dev_sel(dev_sel)
  );

  pio_set_select #(.AW(AW), .DATA_PORT(DATA_PORT)) u_select (
    .addr(req_addr), .dev_sel(dev_sel), .set_cfg(set_cfg),
    .iordy_en(cfg_iordy_en), .fast_en(cfg_fast_en),
    .timing(sel_timing), .iordy_use(sel_iordy)
  );

  pio_phase_ctrl #(.AW(AW), .DW(DW)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_addr(req_addr),
    .start_write(req_write), .start_wdata(req_wdata),
    .start_timing(sel_timing), .start_iordy_en(sel_iordy),
    .dev_iordy(dev_iordy), .dev_rdata(dev_rdata),
    .idle(idle), .done(rsp_valid), .rdata(rsp_rdata),
    .dev_addr(dev_addr), .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
    .dev_wdata(dev_wdata), .dev_wdata_oe(dev_wdata_oe)
  );

  // R1: a cycle starts only from a presented request
  p_start_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R1: response ends the busy period
  p_ack_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy && $past(busy));
endmodule

// File: tb/test_pio_cycle_seq.sv
module test_pio_cycle_seq;
  import pio_seq_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, busy;
  logic [15:0] rsp_rdata;
  logic [31:0] cfgs [3];
  logic [2:0]  iordy_en = 3'b111;
  logic [1:0]  fast_en = 2'b00;
  logic [3:0]  dev_addr;
  logic        dev_rd_stb, dev_wr_stb, dev_wdata_oe;
  logic [15:0] dev_wdata, dev_rdata = '0;
  logic        dev_iordy = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit dev_model = 1'b0;

  pio_cycle_seq i_pio_cycle_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .cfg_cmd_timing(cfgs[0]), .cfg_dev0_timing(cfgs[1]), .cfg_dev1_timing(cfgs[2]),
    .cfg_iordy_en(iordy_en), .cfg_fast_en(fast_en),
    .dev_addr(dev_addr), .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
    .dev_wdata(dev_wdata), .dev_wdata_oe(dev_wdata_oe),
    .dev_rdata(dev_rdata), .dev_iordy(dev_iordy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int set_index(input logic [3:0] a, input bit d, input logic [1:0] fe);
    if (a == 4'd0 && fe[d]) return 1 + int'(d);
    return 0;
  endfunction

  function automatic logic [31:0] mk_tim(input int t1, input int t2, input int t4, input int te);
    return {8'(te), 8'(t4), 8'(t2), 8'(t1)};
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Called at a falling edge where the block is idle or acknowledging.
  task automatic access(input logic [3:0] a, input bit wr, input logic [15:0] wd,
                        input int extra, input bit scramble);
    int idx = set_index(a, dev_model, fast_en);
    logic [31:0] t = cfgs[idx];
    int t1 = int'(t[7:0]);
    int t2 = int'(t[15:8]);
    int t4 = int'(t[23:16]);
    int te = int'(t[31:24]);
    bit en = iordy_en[idx];
    int pre = 0, stb = 0, post = 0, oe = 0, cyc = 0;
    bit seen = 0, wrong_stb = 0, addr_bad = 0, wd_bad = 0;
    logic [15:0] rv = 16'($urandom);
    logic [31:0] saved [3];
    logic [2:0] saved_ie;
    logic [1:0] saved_fe;
    logic strobe, other;
    chk(req_ready === 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 16'($urandom); req_addr = 4'($urandom);
    if (wr && a == 4'd6) dev_model = wd[4];
    chk(busy === 1'b1 && req_ready === 1'b0, "R1", "busy after accept", busy, 1);
    if (scramble) begin
      saved = cfgs; saved_ie = iordy_en; saved_fe = fast_en;
      for (int s = 0; s < 3; s++) cfgs[s] = $urandom;
      iordy_en = ~iordy_en; fast_en = ~fast_en;
    end
    dev_rdata = rv;
    while (rsp_valid !== 1'b1 && cyc < 3000) begin
      cyc++;
      if (dev_addr !== a) addr_bad = 1;
      strobe = wr ? dev_wr_stb : dev_rd_stb;
      other  = wr ? dev_rd_stb : dev_wr_stb;
      if (other) wrong_stb = 1;
      if (dev_wdata_oe) begin
        oe++;
        if (dev_wdata !== wd) wd_bad = 1;
      end
      if (!strobe && !seen) begin
        pre++;
      end else if (strobe) begin
        if (!seen) begin seen = 1; dev_iordy = 1'b0; end
        stb++;
        if (stb == t2 + 1 + extra) dev_iordy = 1'b1;
      end else begin
        if (post == 0) dev_rdata = ~rv;
        post++;
      end
      @(negedge clk);
    end
    dev_iordy = 1'b1;
    if (scramble) begin cfgs = saved; iordy_en = saved_ie; fast_en = saved_fe; end
    chk(rsp_valid === 1'b1, "R4", "acknowledge seen", rsp_valid, 1);
    chk(busy === 1'b0, "R1", "busy low in ack cycle", busy, 0);
    chk(pre == t1 + 1, "R2 R7 R8 R10", "setup cycles", pre, t1 + 1);
    chk(stb == t2 + 1 + (en ? extra : 0), "R3 R9 R7", "strobe cycles", stb,
        t2 + 1 + (en ? extra : 0));
    chk(post == te + 1, "R4 R7", "recovery cycles", post, te + 1);
    chk(!wrong_stb, "R12", "opposite strobe", wrong_stb, 0);
    chk(!addr_bad, "R10", "address stable", addr_bad, 0);
    if (wr) begin
      chk(oe == t1 + 1 + stb + min2(t4, te) + 1, "R6", "write drive cycles", oe,
          t1 + 1 + stb + min2(t4, te) + 1);
      chk(!wd_bad, "R6", "write data value", wd_bad, 0);
    end else begin
      chk(oe == 0, "R6", "no drive on read", oe, 0);
      chk(rsp_rdata === rv, "R5", "read data", rsp_rdata, rv);
    end
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b0 && busy === 1'b0, "R4 R1", "idle after ack",
          {rsp_valid, busy}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 3; s++) cfgs[s] = MODE0_TIMING;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0 && dev_rd_stb === 1'b0 && dev_wr_stb === 1'b0
        && dev_wdata_oe === 1'b0 && rsp_valid === 1'b0, "R11", "state in reset",
        {req_ready, busy, dev_rd_stb, dev_wr_stb, dev_wdata_oe, rsp_valid}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R11", "idle after reset", busy, 0);

    // Mode-0 defaults, command set
    access(4'd0, 1'b0, 16'h0, 0, 0);
    access(4'd2, 1'b1, 16'h1234, 0, 0);
    idle_gap(2);

    // distinct sets
    cfgs[0] = mk_tim(3, 5, 1, 4);
    cfgs[1] = mk_tim(1, 2, 0, 2);
    cfgs[2] = mk_tim(2, 7, 3, 1);
    fast_en = 2'b11; iordy_en = 3'b111;
    // R8: device 0 after reset, device 1 set by write to 6, used at once
    access(4'd0, 1'b0, 16'h0, 0, 0);
    access(4'd6, 1'b1, 16'h0010, 0, 0);
    access(4'd0, 1'b1, 16'hbeef, 0, 0);
    // R8: read of 6 does not change device
    access(4'd6, 1'b0, 16'h0000, 0, 0);
    access(4'd0, 1'b0, 16'h0, 0, 0);
    // back to device 0, IORDY stretch R9
    access(4'd6, 1'b1, 16'h00e0, 0, 0);
    access(4'd0, 1'b0, 16'h0, 3, 0);
    // R9: IORDY ignored when disabled
    iordy_en = 3'b101;
    access(4'd0, 1'b0, 16'h0, 3, 0);
    // R7: fast bit clear -> command set, non-zero address -> command set
    fast_en = 2'b10;
    access(4'd0, 1'b1, 16'h5a5a, 2, 0);
    access(4'd1, 1'b0, 16'h0, 1, 0);
    // R10: config changes mid-cycle ignored
    fast_en = 2'b11;
    access(4'd0, 1'b1, 16'h0f0f, 1, 1);
    // R6: hold longer than recovery
    cfgs[0] = mk_tim(0, 1, 6, 2);
    access(4'd3, 1'b1, 16'hc3c3, 0, 0);
    // all-zero counts
    cfgs[0] = mk_tim(0, 0, 0, 0);
    access(4'd7, 1'b0, 16'h0, 0, 0);
    access(4'd7, 1'b1, 16'h7777, 0, 0);
    idle_gap(1);

    for (int n = 0; n < 40; n++) begin
      logic [3:0] a;
      for (int s = 0; s < 3; s++)
        cfgs[s] = mk_tim($urandom_range(0, 6), $urandom_range(0, 6),
                         $urandom_range(0, 6), $urandom_range(0, 6));
      iordy_en = 3'($urandom);
      fast_en  = 2'($urandom);
      case ($urandom_range(0, 3))
        0, 1: a = 4'd0;
        2: a = 4'd6;
        default: a = 4'($urandom);
      endcase
      access(a, 1'($urandom), 16'($urandom), $urandom_range(0, 3), 1'($urandom_range(0, 4) == 0));
      if ($urandom_range(0, 2) == 0) idle_gap($urandom_range(1, 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule